// File: doc/BRIEF.md
# Texture tile deswizzle writer

The block turns a stream of packed source words into row-ordered texel writes for a texture sheet that is 2048 texels across and 16 bits deep per slot. Source data arrives as 8x8 tiles, each holding its texels in a swizzled order. The block buffers one tile, then emits one sheet write per texel. Each write reads the buffered tile through a fixed permutation of the texel index bits. It places the texel at an address derived from the rectangle origin, the tile position and the texel's row and column.

A rectangle is started with a one-cycle `start` pulse that carries the origin, the width, the height, the texel depth and the byte order. Tiles are taken in row-major order. A 16-bit texel is written to a full sheet slot. An 8-bit greyscale texel is packed: two of them share one slot, so a tile of greyscale texels covers only four slots horizontally. A rectangle with a bad size is refused with an error pulse. After the final texel of an accepted rectangle is written, a done pulse follows.

Source word layout: the byte at `in_word[8*k+7:8*k]` is source byte offset `4*n+k`, where `n` counts the words of the rectangle from zero.

Top module: `tile_deswizzle_writer`

## Requirements
- R1: While reset is held, and afterwards until a start, `busy`, `in_ready`, `wr_en`, `done` and `err` are all 0.
- R2: A start whose width or height is zero or not a multiple of 8 raises `err` for exactly one cycle, in the cycle after the start. No word is requested and no write is made.
- R3: Index mapping: texel i = row*8+col (0..63) reads tile-relative source texel s = {i[5], i[4], i[2], i[1], i[3], i[0]} (MSB first). In 16-bit big-endian mode (`mode16`=1, `little_end`=0) the texel is bytes 2s and 2s+1, with byte 2s as the high byte of `wr_data`.
- R4: In 16-bit little-endian mode, s is formed from i XOR 1, and byte 2s+1 is the high byte of `wr_data`.
- R5: In 8-bit big-endian mode the texel is source byte s of the tile. It appears on both bytes of `wr_data`.
- R6: In 8-bit little-endian mode, s is formed from i XOR 9, which flips bit 0 of both the row and the column.
- R7: A 16-bit texel at sheet position (x, y) is written with `wr_addr` = (y*2048+x)*2 and `wr_be` = 2'b11.
- R8: An 8-bit texel is written with `wr_addr` = (y*2048+tx)*2 + (col AND 6), where tx is the tile's x. `wr_be` is 2'b01 for an even col and 2'b10 for an odd col; bit 0 is the low byte.
- R9: Tiles are taken row-major. Tile (tr, tc) has x = org_x + tc*8 in 16-bit mode and org_x + tc*4 in 8-bit mode, and y = org_y + tr*8. A tile consumes 32 words in 16-bit mode and 16 words in 8-bit mode.
- R10: A word is taken only in a cycle with `in_valid` and `in_ready` both high. `in_ready` is never high in a cycle that writes.
- R11: `done` is high for exactly one cycle, directly after the cycle of the rectangle's last write.
- R12: The 64 writes of a tile occur in consecutive cycles, in index order 0..63. They start in the cycle after the tile's last word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a rectangle (taken only when idle) |
| org_x | input | XBITS | Rectangle origin, texel column |
| org_y | input | YBITS | Rectangle origin, texel row |
| rect_w | input | XBITS+1 | Rectangle width in texels |
| rect_h | input | YBITS+1 | Rectangle height in texels |
| mode16 | input | 1 | 1 = 16-bit colour texels, 0 = 8-bit greyscale |
| little_end | input | 1 | 1 = little-endian source packing |
| in_valid | input | 1 | Source word valid |
| in_ready | output | 1 | Block can take a source word |
| in_word | input | 32 | Source word |
| wr_en | output | 1 | Sheet write strobe |
| wr_addr | output | XBITS+YBITS+1 | Sheet byte address of the 16-bit slot |
| wr_data | output | 16 | Write data |
| wr_be | output | 2 | Byte enables, bit 0 = low byte |
| busy | output | 1 | Rectangle in progress |
| done | output | 1 | One-cycle pulse after the final write |
| err | output | 1 | One-cycle pulse for a refused rectangle |

## Verification
`err` is due one cycle after the start edge. The first write of a tile is due one cycle after its final word is accepted, and each following write comes one cycle later. `done` is due one cycle after the final write. The bench applies every input at a falling edge and samples every output at the next falling edge, so each registered result is observed exactly in the cycle it is due. At each write, the monitor checks that the previous cycle was also a write, except at tile boundaries. At the done pulse, it checks that the previous cycle held the final write.

// File: rtl/tile_deswizzle_writer.sv
module tile_deswizzle_writer #(
  parameter int XBITS = 11,
  parameter int YBITS = 11,
  localparam int AW = XBITS + YBITS + 1,
  localparam int TW = XBITS - 2,
  localparam int TH = YBITS - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [XBITS-1:0] org_x,
  input  logic [YBITS-1:0] org_y,
  input  logic [XBITS:0]   rect_w,
  input  logic [YBITS:0]   rect_h,
  input  logic             mode16,
  input  logic             little_end,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_word,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [15:0]      wr_data,
  output logic [1:0]       wr_be,
  output logic             busy,
  output logic             done,
  output logic             err
);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_WRITE} state_t;

  state_t           state_q;
  logic [XBITS-1:0] ox_q;
  logic [YBITS-1:0] oy_q;
  logic             m16_q, le_q;
  logic [TW-1:0]    ntx_q, tc_q;
  logic [TH-1:0]    nty_q, tr_q;
  logic [4:0]       widx_q;
  logic [5:0]       pix_q;
  logic             done_q, err_q;
  logic [31:0]      tile_mem [32];

  function automatic logic [5:0] swz(input logic [5:0] j);
    return {j[5], j[4], j[2], j[1], j[3], j[0]};
  endfunction

  wire dims_ok  = (rect_w != '0) && (rect_h != '0) &&
                  (rect_w[2:0] == 3'd0) && (rect_h[2:0] == 3'd0);
  wire last_wd  = widx_q == (m16_q ? 5'd31 : 5'd15);
  wire take     = (state_q == S_LOAD) && in_valid;
  wire last_pix = pix_q == 6'd63;
  wire last_col = tc_q == ntx_q - TW'(1);
  wire last_row = tr_q == nty_q - TH'(1);

  assign in_ready = state_q == S_LOAD;
  assign wr_en    = state_q == S_WRITE;
  assign busy     = state_q != S_IDLE;
  assign done     = done_q;
  assign err      = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ox_q    <= '0;
      oy_q    <= '0;
      m16_q   <= 1'b0;
      le_q    <= 1'b0;
      ntx_q   <= '0;
      nty_q   <= '0;
      tc_q    <= '0;
      tr_q    <= '0;
      widx_q  <= '0;
      pix_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          if (dims_ok) begin
            ox_q    <= org_x;
            oy_q    <= org_y;
            m16_q   <= mode16;
            le_q    <= little_end;
            ntx_q   <= rect_w[XBITS:3];
            nty_q   <= rect_h[YBITS:3];
            tc_q    <= '0;
            tr_q    <= '0;
            widx_q  <= '0;
            state_q <= S_LOAD;
          end else begin
            err_q <= 1'b1;
          end
        end
        S_LOAD: if (in_valid) begin
          widx_q <= widx_q + 5'd1;
          if (last_wd) begin
            pix_q   <= '0;
            state_q <= S_WRITE;
          end
        end
        S_WRITE: begin
          pix_q <= pix_q + 6'd1;
          if (last_pix) begin
            widx_q <= '0;
            if (last_col) begin
              tc_q <= '0;
              if (last_row) begin
                state_q <= S_IDLE;
                done_q  <= 1'b1;
              end else begin
                tr_q    <= tr_q + TH'(1);
                state_q <= S_LOAD;
              end
            end else begin
              tc_q    <= tc_q + TW'(1);
              state_q <= S_LOAD;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (take) tile_mem[widx_q] <= in_word;

  wire [2:0]  row = pix_q[5:3];
  wire [2:0]  col = pix_q[2:0];
  wire [5:0]  sel = m16_q ? (pix_q ^ {5'd0, le_q}) : (pix_q ^ {2'd0, le_q, 2'd0, le_q});
  wire [5:0]  src = swz(sel);
  wire [31:0] rd_word = tile_mem[m16_q ? src[5:1] : {1'b0, src[5:2]}];
  wire [15:0] half = src[0] ? rd_word[31:16] : rd_word[15:0];
  wire [7:0]  gray = rd_word[{src[1:0], 3'b000} +: 8];

  wire [XBITS-1:0] tile_x = ox_q + (m16_q ? XBITS'({tc_q, 3'b000}) : XBITS'({tc_q, 2'b00}));
  wire [XBITS-1:0] x_c    = m16_q ? tile_x + XBITS'(col) : tile_x;
  wire [YBITS-1:0] y_c    = oy_q + YBITS'({tr_q, 3'b000}) + YBITS'(row);

  assign wr_addr = {y_c, x_c, 1'b0} + (m16_q ? AW'(0) : AW'({col[2:1], 1'b0}));
  assign wr_data = m16_q ? (le_q ? half : {half[7:0], half[15:8]}) : {gray, gray};
  assign wr_be   = m16_q ? 2'b11 : (col[0] ? 2'b10 : 2'b01);

  a_r10_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && in_ready));
  a_r12_burst: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !last_pix |=> wr_en && (pix_q == $past(pix_q) + 6'd1));
  a_r12_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> $past(in_valid && in_ready));
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en) && !wr_en);
  a_r2_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !wr_en && !in_ready);
  a_r8_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !m16_q |-> $countones(wr_be) == 1);

endmodule

// File: tb/tile_deswizzle_writer_bench.sv
module tile_deswizzle_writer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [10:0] org_x = '0, org_y = '0;
  logic [11:0] rect_w = '0, rect_h = '0;
  logic        mode16 = 1'b0, little_end = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        wr_en;
  logic [22:0] wr_addr;
  logic [15:0] wr_data;
  logic [1:0]  wr_be;
  logic        busy, done, err;

  int nvec = 0, nbad = 0;
  int j_ox, j_oy, j_w, j_h, j_seed;
  bit j_m16, j_le;

  always #4 clk = ~clk;

  tile_deswizzle_writer u_tile_deswizzle_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .org_x(org_x), .org_y(org_y),
    .rect_w(rect_w), .rect_h(rect_h), .mode16(mode16), .little_end(little_end),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .busy(busy), .done(done), .err(err));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  function automatic int sb(input int k);
    return (k * 37 + j_seed * 101 + 3) & 255;
  endfunction

  function automatic logic [31:0] wordk(input int k);
    return {sb(4*k+3)[7:0], sb(4*k+2)[7:0], sb(4*k+1)[7:0], sb(4*k)[7:0]};
  endfunction

  function automatic int pm(input int j);
    return (j & 48) | (((j >> 3) & 1) << 1) | (((j >> 1) & 1) << 2) |
           (((j >> 2) & 1) << 3) | (j & 1);
  endfunction

  task automatic check_write(input int n);
    int t = n / 64, i = n % 64, ntx = j_w / 8;
    int tr = t / ntx, tc = t % ntx, row = i / 8, col = i % 8;
    int bpp = j_m16 ? 2 : 1;
    int base = t * 64 * bpp;
    int s, d, a, be, x, y;
    string dtag, atag;
    y = j_oy + tr * 8 + row;
    if (j_m16) begin
      s = pm(j_le ? (i ^ 1) : i);
      d = j_le ? ((sb(base + 2*s + 1) << 8) | sb(base + 2*s))
               : ((sb(base + 2*s) << 8) | sb(base + 2*s + 1));
      x = j_ox + tc * 8 + col;
      a = (y * 2048 + x) * 2;
      be = 3;
      dtag = j_le ? "R4" : "R3";
      atag = "R7 R9";
    end else begin
      s = pm(j_le ? (i ^ 9) : i);
      d = (sb(base + s) << 8) | sb(base + s);
      x = j_ox + tc * 4;
      a = (y * 2048 + x) * 2 + (col & 6);
      be = (col & 1) ? 2 : 1;
      dtag = j_le ? "R6" : "R5";
      atag = "R8 R9";
    end
    chk(wr_data == 16'(d), dtag, wr_data, d);
    chk({wr_addr, wr_be} == {23'(a), 2'(be)}, atag, {wr_addr, wr_be}, {a, be[1:0]});
    chk(!in_ready, "R10", in_ready, 0);
  endtask

  task automatic run_job(input int ox, oy, w, h, input bit m16, le, gap, input int seed);
    int total = (w / 8) * (h / 8) * 64;
    int nwords = total * (m16 ? 2 : 1) / 4;
    j_ox = ox; j_oy = oy; j_w = w; j_h = h; j_m16 = m16; j_le = le; j_seed = seed;
    @(negedge clk);
    org_x = 11'(ox); org_y = 11'(oy); rect_w = 12'(w); rect_h = 12'(h);
    mode16 = m16; little_end = le; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fork
      begin
        int k = 0, cyc = 0;
        bit v, r;
        while (k < nwords) begin
          v = gap ? ((cyc % 3) != 2) : 1'b1;
          in_valid = v;
          in_word = wordk(k);
          r = v && in_ready;
          @(negedge clk);
          cyc++;
          if (r) k++;
        end
        in_valid = 1'b0;
      end
      begin
        int n = 0, guard = 0;
        bit prev = 1'b0, fin = 1'b0;
        while (!fin && guard < 20000) begin
          if (wr_en) begin
            if (n % 64 != 0) chk(prev, "R12", prev, 1);
            check_write(n);
            n++;
          end
          if (done) begin
            chk(n == total && prev && !wr_en, "R11", n, total);
            fin = 1'b1;
          end
          chk(!err, "R2", err, 0);
          prev = wr_en;
          if (!fin) @(negedge clk);
          guard++;
        end
      end
    join
    @(negedge clk);
    chk(!done && !busy && !in_ready, "R11", {done, busy, in_ready}, 0);
  endtask

  task automatic bad_job(input int w, h);
    @(negedge clk);
    rect_w = 12'(w); rect_h = 12'(h); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    in_valid = 1'b1;
    chk(err && !busy, "R2", {err, busy}, 2);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk(!err && !wr_en && !in_ready && !busy, "R2", {err, wr_en, in_ready, busy}, 0);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, in_ready, wr_en, done, err} == 5'd0, "R1", {busy, in_ready, wr_en, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, in_ready, wr_en, done, err} == 5'd0, "R1", {busy, in_ready, wr_en, done, err}, 0);
    run_job(64, 40, 16, 16, 1'b1, 1'b0, 1'b0, 1);
    run_job(2032, 2032, 16, 16, 1'b1, 1'b1, 1'b0, 2);
    run_job(100, 8, 16, 16, 1'b0, 1'b0, 1'b0, 3);
    run_job(300, 500, 24, 8, 1'b0, 1'b1, 1'b1, 4);
    run_job(0, 0, 8, 8, 1'b1, 1'b1, 1'b1, 5);
    run_job(1000, 1016, 8, 16, 1'b0, 1'b0, 1'b1, 6);
    bad_job(12, 8);
    bad_job(8, 0);
    bad_job(0, 8);
    bad_job(16, 20);
    run_job(16, 16, 8, 8, 1'b0, 1'b1, 1'b0, 7);
    summary();
  end
endmodule